// File: doc/BRIEF.md
# Strided Multi-Vector Predicated Word Load Sequencer

This block carries out a single contiguous load of 32-bit words into two or four vector registers that sit apart from each other in the register file. One instruction supplies a 64-bit base address, a flag saying that the base came from the stack pointer, a signed 4-bit immediate, a register-group field and a mode bit that picks two or four destinations. It also supplies a per-element active mask, already expanded. The block forms the start address from these inputs. It then walks the memory block one word at a time and reads only the elements that are active. When a vector is complete, it writes that vector to its destination register.

The memory port takes one read at a time under a valid/ready request. The response is returned later with its own valid. Each vector reaches the register file through a single write, and done is raised on the last write. When the stack pointer is the base source, an alignment flag is reported together with done.

Top module: `strided_vload_seq`

## Requirements
- R1: After reset, and whenever no instruction is in progress, `idle_o` is 1, and `rd_req_valid`, `rf_we`, `done_o` and `sp_align_err` are all 0.
- R2: The start address is `base_addr + sext(imm4) * NREG * (VLEN/8)`, computed modulo 2^64. NREG is 4 when `quad_mode`=1 and 2 otherwise. `imm4` is two's complement.
- R3: Element e of register r (counted from 0) is at address start + 4*(r*(VLEN/32) + e). The address advances by 4 for every element, active or not. Reads are issued in ascending element order, register 0 first.
- R4: The active bit of element e of register r is `act_mask[r*(VLEN/32)+e]`. An active element takes the word read from its address. An inactive element issues no read, and its 32-bit lane in the written vector is zero. Lane e occupies bits [32e+31:32e].
- R5: With `quad_mode`=0, the destinations are `{grp_hi,1'b0,grp_lo[2:0]}` and that index plus 8.
- R6: With `quad_mode`=1, the destinations are `{grp_hi,2'b00,grp_lo[1:0]}` plus 0, 4, 8 and 12. `grp_lo[2]` has no effect.
- R7: Each destination receives exactly one `rf_we` pulse, in ascending register order, and only after all of its elements have been gathered. `done_o` is high only in the cycle of the last write.
- R8: A request with `rd_req_valid` high and `rd_req_ready` low stays valid with an unchanged address. After a request is accepted, no new request appears until `rd_resp_valid` has been taken.
- R9: A `start_valid` pulse while `idle_o` is 0 is ignored. The running instruction's reads and writes are unchanged, and no extra instruction runs afterwards.
- R10: With an all-zero mask, the block issues no reads and writes all-zero vectors to every destination.
- R11: `sp_align_err` is 1 with `done_o` exactly when `sp_sel`=1 and `base_addr[3:0]` is non-zero. The load is carried out in either case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start_valid | input | 1 | Instruction present; accepted when idle |
| idle_o | output | 1 | No instruction in progress |
| base_addr | input | 64 | Base address |
| sp_sel | input | 1 | Base came from the stack pointer |
| imm4 | input | 4 | Signed vector-group offset |
| grp_hi | input | 1 | Register bank bit (top index bit) |
| grp_lo | input | 3 | Low register-group bits |
| quad_mode | input | 1 | 1: four destinations, 0: two |
| act_mask | input | 4*VLEN/32 | Expanded per-element active mask |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Memory accepts the request |
| rd_addr | output | 64 | Read word address |
| rd_resp_valid | input | 1 | Read data valid |
| rd_resp_data | input | 32 | Read data |
| rf_we | output | 1 | Register-file write strobe |
| rf_idx | output | 5 | Destination register index |
| rf_data | output | VLEN | Vector written |
| done_o | output | 1 | Last write of the instruction |
| sp_align_err | output | 1 | Stack-pointer base misaligned, valid with done |

## Verification
The first request can appear no earlier than the cycle after acceptance. Each active element then needs at least one cycle for the request and one cycle for the response. An inactive element takes one cycle. A write follows the cycle after the last element of its vector. The bench therefore never predicts when a result will occur. Its memory model decides readiness and response delay on the falling edge and records each handshake due at the next rising edge. Falling-edge monitors capture every request and write, and these logs are compared in order against lists computed from the requirements once done is seen.

// File: rtl/svl_pkg.sv
package svl_pkg;
    localparam int ELEM_W     = 32;
    localparam int ELEM_BYTES = ELEM_W / 8;
    localparam int RIDX_W     = 5;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ELEM  = 2'd1,
        ST_WAIT  = 2'd2,
        ST_WRITE = 2'd3
    } svl_state_e;
endpackage

// File: rtl/svl_addr_gen.sv
module svl_addr_gen #(
    parameter int ADDR_W = 64,
    parameter int VB_SH  = 4
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [3:0]        imm,
    input  logic              quad,
    output logic [ADDR_W-1:0] start
);
    localparam int SH_W = $clog2(VB_SH + 3);

    logic [ADDR_W-1:0] imm_x;
    logic [SH_W-1:0]   sh;

    always_comb begin
        imm_x = {{(ADDR_W-4){imm[3]}}, imm};
        sh    = SH_W'(VB_SH) + (quad ? SH_W'(2) : SH_W'(1));
        start = base + (imm_x << sh);
    end
endmodule

// File: rtl/svl_dest_map.sv
module svl_dest_map (
    input  logic       bank,
    input  logic [2:0] grp,
    input  logic       quad,
    input  logic [1:0] reg_n,
    output logic [4:0] idx
);
    always_comb begin
        if (quad) begin
            idx = {bank, reg_n, grp[1:0]};
        end else begin
            idx = {bank, reg_n[0], grp};
        end
    end
endmodule

// File: rtl/svl_mask_sel.sv
module svl_mask_sel #(
    parameter int ELEMS = 4
) (
    input  logic [4*ELEMS-1:0]         mask,
    input  logic [1:0]                 reg_n,
    input  logic [$clog2(ELEMS)-1:0]   elem,
    output logic                       active
);
    localparam int POS_W = $clog2(4 * ELEMS);

    logic [POS_W-1:0] pos;

    always_comb begin
        pos    = {reg_n, elem};
        active = mask[pos];
    end
endmodule

// File: rtl/strided_vload_seq.sv
module strided_vload_seq
    import svl_pkg::*;
#(
    parameter int VLEN   = 128,
    parameter int ADDR_W = 64
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_valid,
    output logic                     idle_o,
    input  logic [ADDR_W-1:0]        base_addr,
    input  logic                     sp_sel,
    input  logic [3:0]               imm4,
    input  logic                     grp_hi,
    input  logic [2:0]               grp_lo,
    input  logic                     quad_mode,
    input  logic [4*(VLEN/32)-1:0]   act_mask,
    output logic                     rd_req_valid,
    input  logic                     rd_req_ready,
    output logic [ADDR_W-1:0]        rd_addr,
    input  logic                     rd_resp_valid,
    input  logic [ELEM_W-1:0]        rd_resp_data,
    output logic                     rf_we,
    output logic [RIDX_W-1:0]        rf_idx,
    output logic [VLEN-1:0]          rf_data,
    output logic                     done_o,
    output logic                     sp_align_err
);
    localparam int ELEMS  = VLEN / ELEM_W;
    localparam int EIW    = $clog2(ELEMS);
    localparam int MASK_W = 4 * ELEMS;
    localparam int VB_SH  = $clog2(VLEN / 8);

    typedef struct packed {
        svl_state_e         st;
        logic [ADDR_W-1:0]  addr;
        logic [1:0]         reg_n;
        logic [EIW-1:0]     elem;
        logic [VLEN-1:0]    vbuf;
        logic               quad;
        logic               bank;
        logic [2:0]         grp;
        logic [MASK_W-1:0]  mask;
        logic               misal;
    } ctx_t;

    ctx_t ctx_d, ctx_q;

    logic [ADDR_W-1:0] start_addr;
    logic              elem_active;
    logic              adv;
    logic [ELEM_W-1:0] adv_word;
    logic              last_reg;

    svl_addr_gen #(
        .ADDR_W (ADDR_W),
        .VB_SH  (VB_SH)
    ) u_addr (
        .base  (base_addr),
        .imm   (imm4),
        .quad  (quad_mode),
        .start (start_addr)
    );

    svl_mask_sel #(
        .ELEMS (ELEMS)
    ) u_mask (
        .mask   (ctx_q.mask),
        .reg_n  (ctx_q.reg_n),
        .elem   (ctx_q.elem),
        .active (elem_active)
    );

    svl_dest_map u_dest (
        .bank  (ctx_q.bank),
        .grp   (ctx_q.grp),
        .quad  (ctx_q.quad),
        .reg_n (ctx_q.reg_n),
        .idx   (rf_idx)
    );

    always_comb begin
        ctx_d        = ctx_q;
        rd_req_valid = 1'b0;
        rf_we        = 1'b0;
        done_o       = 1'b0;
        adv          = 1'b0;
        adv_word     = '0;
        last_reg     = ctx_q.quad ? (ctx_q.reg_n == 2'd3) : (ctx_q.reg_n == 2'd1);

        case (ctx_q.st)
            ST_IDLE: begin
                if (start_valid) begin
                    ctx_d.st    = ST_ELEM;
                    ctx_d.addr  = start_addr;
                    ctx_d.reg_n = '0;
                    ctx_d.elem  = '0;
                    ctx_d.quad  = quad_mode;
                    ctx_d.bank  = grp_hi;
                    ctx_d.grp   = grp_lo;
                    ctx_d.mask  = act_mask;
                    ctx_d.misal = sp_sel && (base_addr[3:0] != 4'd0);
                end
            end
            ST_ELEM: begin
                if (elem_active) begin
                    rd_req_valid = 1'b1;
                    if (rd_req_ready) begin
                        ctx_d.st = ST_WAIT;
                    end
                end else begin
                    adv = 1'b1;
                end
            end
            ST_WAIT: begin
                if (rd_resp_valid) begin
                    adv      = 1'b1;
                    adv_word = rd_resp_data;
                end
            end
            ST_WRITE: begin
                rf_we = 1'b1;
                if (last_reg) begin
                    done_o   = 1'b1;
                    ctx_d.st = ST_IDLE;
                end else begin
                    ctx_d.reg_n = ctx_q.reg_n + 2'd1;
                    ctx_d.elem  = '0;
                    ctx_d.st    = ST_ELEM;
                end
            end
            default: ctx_d.st = ST_IDLE;
        endcase

        if (adv) begin
            ctx_d.vbuf[ctx_q.elem*ELEM_W +: ELEM_W] = adv_word;
            ctx_d.addr = ctx_q.addr + ADDR_W'(ELEM_BYTES);
            ctx_d.elem = ctx_q.elem + EIW'(1);
            ctx_d.st   = (ctx_q.elem == EIW'(ELEMS - 1)) ? ST_WRITE : ST_ELEM;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctx_q <= '0;
        end else begin
            ctx_q <= ctx_d;
        end
    end

    assign idle_o       = (ctx_q.st == ST_IDLE);
    assign rd_addr      = ctx_q.addr;
    assign rf_data      = ctx_q.vbuf;
    assign sp_align_err = done_o && ctx_q.misal;

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        idle_o |-> (!rd_req_valid && !rf_we && !done_o)); // R1
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_addr))); // R8
    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_valid && rd_req_ready) |=> !rd_req_valid); // R8
    AST_DONE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> rf_we); // R7
    AST_NO_EARLY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (start_valid && idle_o) |=> !rf_we); // R7
    AST_ALIGN_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        sp_align_err |-> done_o); // R11
endmodule

// File: tb/tb_strided_vload_seq.sv
module tb_strided_vload_seq;
    localparam int VLEN  = 128;
    localparam int ELEMS = VLEN / 32;
    localparam int MW    = 4 * ELEMS;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start_valid = 1'b0;
    logic            idle_o;
    logic [63:0]     base_addr = '0;
    logic            sp_sel = 1'b0;
    logic [3:0]      imm4 = '0;
    logic            grp_hi = 1'b0;
    logic [2:0]      grp_lo = '0;
    logic            quad_mode = 1'b0;
    logic [MW-1:0]   act_mask = '0;
    logic            rd_req_valid;
    logic            rd_req_ready = 1'b0;
    logic [63:0]     rd_addr;
    logic            rd_resp_valid = 1'b0;
    logic [31:0]     rd_resp_data = '0;
    logic            rf_we;
    logic [4:0]      rf_idx;
    logic [VLEN-1:0] rf_data;
    logic            done_o;
    logic            sp_align_err;

    strided_vload_seq #(.VLEN(VLEN), .ADDR_W(64)) dut (
        .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .idle_o(idle_o),
        .base_addr(base_addr), .sp_sel(sp_sel), .imm4(imm4), .grp_hi(grp_hi),
        .grp_lo(grp_lo), .quad_mode(quad_mode), .act_mask(act_mask),
        .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_addr(rd_addr),
        .rd_resp_valid(rd_resp_valid), .rd_resp_data(rd_resp_data),
        .rf_we(rf_we), .rf_idx(rf_idx), .rf_data(rf_data), .done_o(done_o),
        .sp_align_err(sp_align_err)
    );

    always #4 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit running = 1'b0;

    int          rcnt;
    logic [63:0] rlog [16];
    int          proto_bad;
    bit          pend;
    int          dly;
    logic [63:0] paddr;
    bit          prev_stall;
    logic [63:0] prev_addr;

    int              wcnt;
    logic [4:0]      widx [8];
    logic [VLEN-1:0] wdat [8];
    bit              wdone [8];
    bit              werr [8];

    function automatic logic [31:0] memf(input logic [63:0] a);
        return a[31:0] ^ a[63:32] ^ 32'h3C5A_96E1;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    initial begin
        #(8 * 190000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // memory model: decisions on the falling edge for the next rising edge
    initial begin
        pend = 0; proto_bad = 0; prev_stall = 0; dly = 0; paddr = '0; prev_addr = '0;
        forever begin
            @(negedge clk);
            if (running) begin
                if (pend) begin
                    if (rd_resp_valid) begin
                        rd_resp_valid = 1'b0;
                        pend = 0;
                    end else if (dly == 0) begin
                        rd_resp_valid = 1'b1;
                        rd_resp_data  = memf(paddr);
                    end else begin
                        dly--;
                    end
                end
                if (prev_stall && (!rd_req_valid || rd_addr != prev_addr)) proto_bad++;
                if (!pend) begin
                    rd_req_ready = ($urandom % 4) != 0;
                    #1;
                    prev_stall = rd_req_valid && !rd_req_ready;
                    prev_addr  = rd_addr;
                    if (rd_req_valid && rd_req_ready) begin
                        pend  = 1;
                        paddr = rd_addr;
                        dly   = $urandom % 3;
                        if (rcnt < 16) rlog[rcnt] = rd_addr;
                        rcnt++;
                    end
                end else begin
                    rd_req_ready = 1'b0;
                    #1;
                    if (rd_req_valid) proto_bad++;
                    prev_stall = 0;
                end
            end
        end
    end

    // register-file write monitor
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (running && rf_we) begin
                if (wcnt < 8) begin
                    widx[wcnt]  = rf_idx;
                    wdat[wcnt]  = rf_data;
                    wdone[wcnt] = done_o;
                    werr[wcnt]  = sp_align_err;
                end
                wcnt++;
            end
        end
    end

    task automatic run_instr(input logic [63:0] b, input bit sp, input logic [3:0] im,
                             input bit hi, input logic [2:0] lo, input bit qd,
                             input logic [MW-1:0] m, input bit poke);
        int nreg = qd ? 4 : 2;
        logic [63:0] sx = {{60{im[3]}}, im};
        logic [63:0] st = b + sx * 64'(nreg * (VLEN / 8));
        logic [63:0] ea [16];
        int k = 0;
        int to = 0;
        bit addr_ok = 1;
        bit seen = 0;
        rcnt = 0; wcnt = 0; proto_bad = 0;
        for (int r = 0; r < nreg; r++)
            for (int e = 0; e < ELEMS; e++)
                if (m[r*ELEMS+e]) begin
                    ea[k] = st + 64'(4 * (r * ELEMS + e));
                    k++;
                end
        @(negedge clk);
        base_addr = b; sp_sel = sp; imm4 = im; grp_hi = hi; grp_lo = lo;
        quad_mode = qd; act_mask = m; start_valid = 1'b1;
        @(negedge clk);
        start_valid = 1'b0;
        base_addr = ~b; imm4 = ~im; quad_mode = ~qd; act_mask = ~m; grp_lo = ~lo; sp_sel = ~sp;
        if (poke) begin
            repeat (2) @(negedge clk);
            start_valid = 1'b1;
            @(negedge clk);
            start_valid = 1'b0;
        end
        while (!seen && to < 600) begin
            @(negedge clk);
            #3;
            if (wcnt > 0 && wcnt <= 8 && wdone[wcnt-1]) seen = 1;
            to++;
        end
        chk(seen, "R7 done seen", 128'(seen), 128'(1));
        chk(rcnt == k, (k == 0) ? "R10 read count" : "R4 read count", 128'(rcnt), 128'(k));
        for (int i = 0; i < k && i < rcnt && i < 16; i++)
            if (rlog[i] != ea[i]) addr_ok = 0;
        chk(addr_ok, "R3 read address order", 128'(rcnt > 0 ? rlog[0] : 64'd0), 128'(k > 0 ? ea[0] : 64'd0));
        chk(proto_bad == 0, "R8 request protocol", 128'(proto_bad), 128'(0));
        chk(wcnt == nreg, "R7 write count", 128'(wcnt), 128'(nreg));
        for (int r = 0; r < nreg && r < wcnt; r++) begin
            logic [4:0] xi = qd ? ({hi, 2'b00, lo[1:0]} + 5'(4 * r)) : ({hi, 1'b0, lo} + 5'(8 * r));
            logic [VLEN-1:0] xd = '0;
            bit xe = (r == nreg - 1) && sp && (b[3:0] != 4'd0);
            for (int e = 0; e < ELEMS; e++)
                if (m[r*ELEMS+e]) xd[e*32 +: 32] = memf(st + 64'(4 * (r * ELEMS + e)));
            chk(widx[r] == xi, qd ? "R6 dest index" : "R5 dest index", 128'(widx[r]), 128'(xi));
            chk(wdat[r] == xd, (m == '0) ? "R10 zero data" : "R4 vector data", 128'(wdat[r]), 128'(xd));
            chk(wdone[r] == (r == nreg - 1), "R7 done only on last write", 128'(wdone[r]), 128'(r == nreg - 1));
            chk(werr[r] == xe, "R11 sp alignment flag", 128'(werr[r]), 128'(xe));
        end
        if (poke) begin
            repeat (10) @(negedge clk);
            #3;
            chk(wcnt == nreg && rcnt == k && idle_o, "R9 start ignored while busy",
                128'({wcnt[7:0], rcnt[7:0]}), 128'({8'(nreg), 8'(k)}));
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #2;
        chk(idle_o == 1'b1, "R1 idle after reset", 128'(idle_o), 128'(1));
        chk(rd_req_valid == 1'b0 && rf_we == 1'b0, "R1 quiet after reset", 128'({rd_req_valid, rf_we}), 128'(0));
        chk(done_o == 1'b0 && sp_align_err == 1'b0, "R1 no done after reset", 128'({done_o, sp_align_err}), 128'(0));
        rst_n = 1'b1;
        running = 1'b1;
        void'($urandom(32'd1234));
        // directed cases
        run_instr(64'h0000_0000_0000_1000, 0, 4'd0, 0, 3'd5, 0, 16'h00FF, 0);  // R2 R5 full pair
        run_instr(64'h0000_0000_0000_0010, 0, 4'b1000, 1, 3'd7, 1, 16'hFFFF, 0); // R2 wrap, R6
        run_instr(64'h0000_0000_0000_2000, 0, 4'd3, 1, 3'd6, 1, 16'hA5C3, 0);  // R6 grp_lo[2] set
        run_instr(64'h0000_0000_0000_3000, 0, 4'd1, 0, 3'd2, 1, 16'h0000, 0);  // R10 quad
        run_instr(64'h0000_0000_0000_4000, 0, 4'd7, 0, 3'd0, 0, 16'h0000, 0);  // R10 pair
        run_instr(64'h0000_0000_0000_5008, 1, 4'd0, 0, 3'd1, 0, 16'h0081, 0);  // R11 misaligned
        run_instr(64'h0000_0000_0000_5000, 1, 4'd2, 1, 3'd3, 0, 16'h0042, 0);  // R11 aligned
        run_instr(64'hFFFF_FFFF_FFFF_FFF0, 0, 4'd7, 1, 3'd1, 1, 16'h1248, 1);  // R9 poke, R2 wrap
        run_instr(64'h0000_0000_0000_6000, 0, 4'd0, 0, 3'd4, 0, 16'h8001, 1);  // R9 poke pair
        for (int i = 0; i < 40; i++) begin
            logic [63:0] rb = {$urandom, $urandom};
            run_instr(rb, 1'($urandom), 4'($urandom), 1'($urandom), 3'($urandom),
                      1'($urandom), 16'($urandom), (i % 8) == 3);
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule